// File: doc/BRIEF.md
# Stack Load/Store Address Unit

This unit sits beside the execute stage of a stack machine and turns the eight memory opcodes into requests for a single memory port. The address always comes from the top of the operand stack. For stores, the value comes from the entry just below it. The unit moves either a full 64-bit cell or a single byte. Each size has a plain form and a post-incrementing form. The post-incrementing form leaves the advanced address on the stack.

Each request carries a byte-enable mask, write data already placed in its byte lane, and a cacheability tag taken only from a fixed address boundary. It also carries a debug flag, which is raised when a cell address was misaligned and had to be rounded down. The unit holds one request at a time. When the port accepts the request, the unit emits a one-cycle stack update for the execute stage:

- the new top and second entries of the stack, with write strobes;
- the net change in stack depth.

Top module: `stk_lsu`

## Requirements
- R1: After reset, `busy`, `req_valid`, `req_misalign` and `upd_valid` are all 0.
- R2: `op_code` bit 2 selects byte (1) or cell (0), bit 1 selects store (1) or fetch (0), and bit 0 selects post-increment. A cell request drives `req_be` = 0xFF and an address with its low three bits cleared. `req_misalign` is 1 exactly when those three bits were not zero on `stk_top`.
- R3: A byte request issues the address unchanged, with `req_misalign` = 0. `req_be` has the single bit set whose index is the address's low three bits.
- R4: A byte store places `stk_next[7:0]` in the byte lane chosen by the address's low three bits, and drives the other lanes with zero. A byte fetch returns that lane of `mem_rdata`, zero-extended to 64 bits. A cell store drives `stk_next` unchanged.
- R5: `req_cacheable` is 1 when the issued address is below 2^32 and 0 when it is at or above 2^32.
- R6: An op is accepted on a clock edge where `op_valid` is 1 and no request is pending. `req_valid` rises one cycle after acceptance. All request fields stay unchanged until an edge where `mem_ready` is 1. On the cycle after that edge, `req_valid` is 0 and `upd_valid` is 1, for that one cycle only.
- R7: `upd_delta` is a 3-bit two's-complement depth change. For a plain fetch, `upd_top` is the fetched data, `upd_delta` is 0 and `upd_next_wr` is 0. For a fetch with increment, `upd_top` is the fetched data, `upd_next` is the issued address plus the step (8 for a cell, 1 for a byte), `upd_next_wr` is 1 and `upd_delta` is +1.
- R8: A plain store gives `upd_delta` = -2 and `upd_top_wr` = 0. A store with increment gives `upd_top` = issued address plus step, `upd_top_wr` = 1 and `upd_delta` = -1.
- R9: While a request is pending, `op_valid` is ignored. Once the pending request completes, no further request is issued from ops presented during the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A memory opcode is presented |
| op_code | input | 3 | {byte, store, increment} |
| stk_top | input | 64 | Top of operand stack (address) |
| stk_next | input | 64 | Second stack entry (store value) |
| mem_ready | input | 1 | Memory port accepts the held request |
| mem_rdata | input | 64 | Read data, valid with mem_ready |
| busy | output | 1 | A request is pending |
| req_valid | output | 1 | Request is being presented |
| req_addr | output | 64 | Issued byte address |
| req_we | output | 1 | Write request |
| req_be | output | 8 | Byte enables |
| req_wdata | output | 64 | Lane-placed write data |
| req_cacheable | output | 1 | Address below 4 GiB |
| req_misalign | output | 1 | Cell address was rounded down |
| upd_valid | output | 1 | Stack update pulse |
| upd_top | output | 64 | New top-of-stack value |
| upd_top_wr | output | 1 | upd_top must be written |
| upd_next | output | 64 | New second entry value |
| upd_next_wr | output | 1 | upd_next must be written |
| upd_delta | output | 3 | Signed stack depth change |

## Verification
The bench builds the unit with its default parameters: a 64-bit cell and the cacheability boundary at bit 32. With these values, addresses just below and exactly at 4 GiB are practical stimuli, as is the carry of an incremented byte address across that boundary. The eight-byte cell gives every lane position from 0 to 7 a distinct enable and data placement to check. The wait on the memory port is varied so that the held request and the ignored ops can be observed over several cycles.

// File: rtl/stk_lsu_pkg.sv
package stk_lsu_pkg;

    // op_code bits: [2] byte size, [1] store, [0] post-increment
    typedef enum logic [2:0] {
        OP_CELL_FETCH     = 3'b000,
        OP_CELL_FETCH_INC = 3'b001,
        OP_CELL_STORE     = 3'b010,
        OP_CELL_STORE_INC = 3'b011,
        OP_BYTE_FETCH     = 3'b100,
        OP_BYTE_FETCH_INC = 3'b101,
        OP_BYTE_STORE     = 3'b110,
        OP_BYTE_STORE_INC = 3'b111
    } lsu_op_e;

    localparam int OPB_BYTE  = 2;
    localparam int OPB_STORE = 1;
    localparam int OPB_INC   = 0;

    // two's-complement stack depth changes
    localparam logic [2:0] DEPTH_KEEP  = 3'b000;
    localparam logic [2:0] DEPTH_PUSH1 = 3'b001;
    localparam logic [2:0] DEPTH_POP1  = 3'b111;
    localparam logic [2:0] DEPTH_POP2  = 3'b110;

endpackage

// File: rtl/stk_lsu_addr_gen.sv
module stk_lsu_addr_gen #(
    parameter int CELL_W           = 64,
    parameter int CACHE_BOUND_LOG2 = 32
) (
    input  logic [CELL_W-1:0]   addr_in,
    input  logic                is_byte,
    output logic [CELL_W-1:0]   addr_out,
    output logic [CELL_W-1:0]   addr_next,
    output logic [CELL_W/8-1:0] be,
    output logic                misalign,
    output logic                cacheable
);
    localparam int CELL_BYTES = CELL_W / 8;
    localparam int LANE_W     = $clog2(CELL_BYTES);

    logic [LANE_W-1:0] lane;
    logic [CELL_W-1:0] step;

    assign lane = addr_in[LANE_W-1:0];

    always_comb begin
        if (is_byte) begin
            addr_out = addr_in;
            be       = {{(CELL_BYTES-1){1'b0}}, 1'b1} << lane;
            misalign = 1'b0;
            step     = CELL_W'(1);
        end else begin
            addr_out = {addr_in[CELL_W-1:LANE_W], {LANE_W{1'b0}}};
            be       = '1;
            misalign = |lane;
            step     = CELL_W'(CELL_BYTES);
        end
        addr_next = addr_out + step;
    end

    generate
        if (CACHE_BOUND_LOG2 >= CELL_W) begin : g_all_cached
            assign cacheable = 1'b1;
        end else begin : g_bound
            assign cacheable = ~|addr_out[CELL_W-1:CACHE_BOUND_LOG2];
        end
    endgenerate

endmodule

// File: rtl/stk_lsu_lane.sv
module stk_lsu_lane #(
    parameter int CELL_W = 64
) (
    input  logic [$clog2(CELL_W/8)-1:0] wr_lane,
    input  logic                        wr_byte,
    input  logic [CELL_W-1:0]           wr_src,
    output logic [CELL_W-1:0]           wr_data,
    input  logic [$clog2(CELL_W/8)-1:0] rd_lane,
    input  logic                        rd_byte,
    input  logic [CELL_W-1:0]           rd_raw,
    output logic [CELL_W-1:0]           rd_data
);
    localparam int CELL_BYTES = CELL_W / 8;
    localparam int LANE_W     = $clog2(CELL_BYTES);

    generate
        for (genvar g = 0; g < CELL_BYTES; g++) begin : g_wr_lane
            always_comb begin
                if (!wr_byte)
                    wr_data[8*g +: 8] = wr_src[8*g +: 8];
                else if (wr_lane == LANE_W'(g))
                    wr_data[8*g +: 8] = wr_src[7:0];
                else
                    wr_data[8*g +: 8] = 8'h00;
            end
        end
    endgenerate

    logic [7:0] rd_sel;
    assign rd_sel  = rd_raw[{rd_lane, 3'b000} +: 8];
    assign rd_data = rd_byte ? {{(CELL_W-8){1'b0}}, rd_sel} : rd_raw;

endmodule

// File: rtl/stk_lsu_stack_fmt.sv
module stk_lsu_stack_fmt
    import stk_lsu_pkg::*;
#(
    parameter int CELL_W = 64
) (
    input  logic [2:0]        op,
    input  logic [CELL_W-1:0] addr_next,
    input  logic [CELL_W-1:0] rd_data,
    output logic [CELL_W-1:0] top,
    output logic              top_wr,
    output logic [CELL_W-1:0] next,
    output logic              next_wr,
    output logic [2:0]        delta
);
    always_comb begin
        top     = '0;
        top_wr  = 1'b0;
        next    = '0;
        next_wr = 1'b0;
        delta   = DEPTH_KEEP;
        unique case ({op[OPB_STORE], op[OPB_INC]})
            2'b00: begin
                top    = rd_data;
                top_wr = 1'b1;
            end
            2'b01: begin
                top     = rd_data;
                top_wr  = 1'b1;
                next    = addr_next;
                next_wr = 1'b1;
                delta   = DEPTH_PUSH1;
            end
            2'b10: begin
                delta = DEPTH_POP2;
            end
            default: begin
                top    = addr_next;
                top_wr = 1'b1;
                delta  = DEPTH_POP1;
            end
        endcase
    end

endmodule

// File: rtl/stk_lsu.sv
module stk_lsu
    import stk_lsu_pkg::*;
#(
    parameter int CELL_W           = 64,
    parameter int CACHE_BOUND_LOG2 = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [2:0]          op_code,
    input  logic [CELL_W-1:0]   stk_top,
    input  logic [CELL_W-1:0]   stk_next,
    input  logic                mem_ready,
    input  logic [CELL_W-1:0]   mem_rdata,
    output logic                busy,
    output logic                req_valid,
    output logic [CELL_W-1:0]   req_addr,
    output logic                req_we,
    output logic [CELL_W/8-1:0] req_be,
    output logic [CELL_W-1:0]   req_wdata,
    output logic                req_cacheable,
    output logic                req_misalign,
    output logic                upd_valid,
    output logic [CELL_W-1:0]   upd_top,
    output logic                upd_top_wr,
    output logic [CELL_W-1:0]   upd_next,
    output logic                upd_next_wr,
    output logic [2:0]          upd_delta
);
    localparam int CELL_BYTES = CELL_W / 8;
    localparam int LANE_W     = $clog2(CELL_BYTES);

    typedef struct packed {
        logic                  req_valid;
        logic [CELL_W-1:0]     addr;
        logic                  we;
        logic [CELL_BYTES-1:0] be;
        logic [CELL_W-1:0]     wdata;
        logic                  cacheable;
        logic                  misalign;
        logic [2:0]            op;
        logic [CELL_W-1:0]     addr_next;
        logic                  upd_valid;
        logic [CELL_W-1:0]     upd_top;
        logic                  upd_top_wr;
        logic [CELL_W-1:0]     upd_next;
        logic                  upd_next_wr;
        logic [2:0]            upd_delta;
    } lsu_state_t;

    lsu_state_t state_d, state_q;

    // address path on the incoming op
    logic [CELL_W-1:0]     ag_addr, ag_addr_next;
    logic [CELL_BYTES-1:0] ag_be;
    logic                  ag_misalign, ag_cacheable;

    stk_lsu_addr_gen #(
        .CELL_W          (CELL_W),
        .CACHE_BOUND_LOG2(CACHE_BOUND_LOG2)
    ) u_addr_gen (
        .addr_in  (stk_top),
        .is_byte  (op_code[OPB_BYTE]),
        .addr_out (ag_addr),
        .addr_next(ag_addr_next),
        .be       (ag_be),
        .misalign (ag_misalign),
        .cacheable(ag_cacheable)
    );

    // lane placement: write side on the incoming op, read side on the held op
    logic [CELL_W-1:0] ln_wdata, ln_rdata;

    stk_lsu_lane #(.CELL_W(CELL_W)) u_lane (
        .wr_lane(stk_top[LANE_W-1:0]),
        .wr_byte(op_code[OPB_BYTE]),
        .wr_src (stk_next),
        .wr_data(ln_wdata),
        .rd_lane(state_q.addr[LANE_W-1:0]),
        .rd_byte(state_q.op[OPB_BYTE]),
        .rd_raw (mem_rdata),
        .rd_data(ln_rdata)
    );

    // stack update for the held op
    logic [CELL_W-1:0] fm_top, fm_next;
    logic              fm_top_wr, fm_next_wr;
    logic [2:0]        fm_delta;

    stk_lsu_stack_fmt #(.CELL_W(CELL_W)) u_fmt (
        .op       (state_q.op),
        .addr_next(state_q.addr_next),
        .rd_data  (ln_rdata),
        .top      (fm_top),
        .top_wr   (fm_top_wr),
        .next     (fm_next),
        .next_wr  (fm_next_wr),
        .delta    (fm_delta)
    );

    always_comb begin
        state_d           = state_q;
        state_d.upd_valid = 1'b0;
        if (state_q.req_valid) begin
            if (mem_ready) begin
                state_d.req_valid   = 1'b0;
                state_d.upd_valid   = 1'b1;
                state_d.upd_top     = fm_top;
                state_d.upd_top_wr  = fm_top_wr;
                state_d.upd_next    = fm_next;
                state_d.upd_next_wr = fm_next_wr;
                state_d.upd_delta   = fm_delta;
            end
        end else if (op_valid) begin
            state_d.req_valid = 1'b1;
            state_d.addr      = ag_addr;
            state_d.we        = op_code[OPB_STORE];
            state_d.be        = ag_be;
            state_d.wdata     = ln_wdata;
            state_d.cacheable = ag_cacheable;
            state_d.misalign  = ag_misalign;
            state_d.op        = op_code;
            state_d.addr_next = ag_addr_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign busy          = state_q.req_valid;
    assign req_valid     = state_q.req_valid;
    assign req_addr      = state_q.addr;
    assign req_we        = state_q.we;
    assign req_be        = state_q.be;
    assign req_wdata     = state_q.wdata;
    assign req_cacheable = state_q.cacheable;
    assign req_misalign  = state_q.misalign & state_q.req_valid;
    assign upd_valid     = state_q.upd_valid;
    assign upd_top       = state_q.upd_top;
    assign upd_top_wr    = state_q.upd_top_wr;
    assign upd_next      = state_q.upd_next;
    assign upd_next_wr   = state_q.upd_next_wr;
    assign upd_delta     = state_q.upd_delta;

    // R6: request fields frozen while the port stalls
    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !mem_ready |=> req_valid && $stable(req_addr) &&
        $stable(req_be) && $stable(req_wdata) && $stable(req_we));

    // R6: acceptance by the port yields one update and drops the request
    p_update_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && mem_ready |=> upd_valid && !req_valid);

    p_update_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> !upd_valid);

    // R2: a full-cell enable mask always sits on an aligned address
    p_cell_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (&req_be) |-> req_addr[LANE_W-1:0] == '0);

    // R3: a partial mask is a single byte and never flags misalignment
    p_byte_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !(&req_be) |-> $onehot(req_be) && !req_misalign);

    // R9: ops presented during a pending request do not restart it
    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !mem_ready && op_valid |=> $stable(req_addr));

endmodule

// File: tb/stk_lsu_tb.sv
module stk_lsu_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [2:0]  op_code;
    logic [63:0] stk_top, stk_next, mem_rdata;
    logic        mem_ready;
    logic        busy, req_valid, req_we, req_cacheable, req_misalign;
    logic [63:0] req_addr, req_wdata;
    logic [7:0]  req_be;
    logic        upd_valid, upd_top_wr, upd_next_wr;
    logic [63:0] upd_top, upd_next;
    logic [2:0]  upd_delta;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    stk_lsu u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .stk_top(stk_top), .stk_next(stk_next), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .busy(busy), .req_valid(req_valid),
        .req_addr(req_addr), .req_we(req_we), .req_be(req_be),
        .req_wdata(req_wdata), .req_cacheable(req_cacheable),
        .req_misalign(req_misalign), .upd_valid(upd_valid),
        .upd_top(upd_top), .upd_top_wr(upd_top_wr), .upd_next(upd_next),
        .upd_next_wr(upd_next_wr), .upd_delta(upd_delta)
    );

    // observations of the last op
    logic [63:0] o_addr, o_wdata, u_top, u_next;
    logic [7:0]  o_be;
    logic        o_valid, o_we, o_cache, o_mis, o_stable;
    logic        u_valid, u_top_wr, u_next_wr, post_req, post_upd;
    logic [2:0]  u_delta;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] op, input logic [63:0] top, input logic [63:0] nxt,
                         input int wait_cyc, input logic [63:0] rdata);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; stk_top = top; stk_next = nxt;
        @(negedge clk);
        op_valid = 1'b0;
        o_valid = req_valid; o_addr = req_addr; o_we = req_we; o_be = req_be;
        o_wdata = req_wdata; o_cache = req_cacheable; o_mis = req_misalign;
        o_stable = 1'b1;
        for (int i = 0; i < wait_cyc; i++) begin
            op_valid = 1'b1; op_code = 3'b011; stk_top = 64'h5555_0000_0000_0101;
            @(negedge clk);
            if (!req_valid || req_addr !== o_addr || req_be !== o_be ||
                req_wdata !== o_wdata || req_we !== o_we) o_stable = 1'b0;
        end
        op_valid = 1'b0;
        mem_ready = 1'b1; mem_rdata = rdata;
        @(negedge clk);
        mem_ready = 1'b0;
        u_valid = upd_valid; u_top = upd_top; u_top_wr = upd_top_wr;
        u_next = upd_next; u_next_wr = upd_next_wr; u_delta = upd_delta;
        post_req = req_valid;
        @(negedge clk);
        post_upd = upd_valid;
        post_req = post_req | req_valid;
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 req_valid", req_valid, 0);
        chk("R1 misalign", req_misalign, 0);
        chk("R1 upd_valid", upd_valid, 0);
    endtask

    task automatic t_cell_fetch();
        do_op(3'b000, 64'h1000, 64'h0, 0, 64'hDEAD_BEEF_0123_4567);
        chk("R6 req_valid", o_valid, 1);
        chk("R2 addr", o_addr, 64'h1000);
        chk("R2 be", o_be, 8'hFF);
        chk("R2 misalign", o_mis, 0);
        chk("R5 cacheable low", o_cache, 1);
        chk("R6 upd_valid", u_valid, 1);
        chk("R6 req dropped", post_req, 0);
        chk("R6 upd pulse", post_upd, 0);
        chk("R7 top", u_top, 64'hDEAD_BEEF_0123_4567);
        chk("R7 delta", u_delta, 3'b000);
        chk("R7 next_wr", u_next_wr, 0);
    endtask

    task automatic t_cell_fetch_inc_misaligned();
        do_op(3'b001, 64'h1_0000_0013, 64'h0, 3, 64'h0BAD_F00D_0000_0001);
        chk("R2 rounded addr", o_addr, 64'h1_0000_0010);
        chk("R2 misalign flag", o_mis, 1);
        chk("R5 cacheable high", o_cache, 0);
        chk("R6 stable during wait", o_stable, 1);
        chk("R9 no extra request", post_req, 0);
        chk("R7 top", u_top, 64'h0BAD_F00D_0000_0001);
        chk("R7 next", u_next, 64'h1_0000_0018);
        chk("R7 next_wr", u_next_wr, 1);
        chk("R7 delta", u_delta, 3'b001);
    endtask

    task automatic t_cell_store();
        do_op(3'b010, 64'hFFFF_FFF8, 64'hA5A5_0000_1234_5678, 1, 64'h0);
        chk("R2 we", o_we, 1);
        chk("R4 cell wdata", o_wdata, 64'hA5A5_0000_1234_5678);
        chk("R5 below bound", o_cache, 1);
        chk("R8 delta", u_delta, 3'b110);
        chk("R8 top_wr", u_top_wr, 0);
    endtask

    task automatic t_cell_store_inc();
        do_op(3'b011, 64'h1_0000_0000, 64'h77, 0, 64'h0);
        chk("R5 at bound", o_cache, 0);
        chk("R8 top", u_top, 64'h1_0000_0008);
        chk("R8 top_wr", u_top_wr, 1);
        chk("R8 delta", u_delta, 3'b111);
    endtask

    task automatic t_byte_fetch();
        do_op(3'b100, 64'h2005, 64'h0, 2, 64'h1122_3344_5566_7788);
        chk("R3 addr", o_addr, 64'h2005);
        chk("R3 be", o_be, 8'h20);
        chk("R3 misalign", o_mis, 0);
        chk("R4 zero extend", u_top, 64'h33);
        chk("R7 delta", u_delta, 3'b000);
    endtask

    task automatic t_byte_fetch_inc();
        do_op(3'b101, 64'h7, 64'h0, 0, 64'h1122_3344_5566_7788);
        chk("R3 be lane7", o_be, 8'h80);
        chk("R4 lane7", u_top, 64'h11);
        chk("R7 next", u_next, 64'h8);
        chk("R7 delta", u_delta, 3'b001);
    endtask

    task automatic t_byte_store();
        do_op(3'b110, 64'h3003, 64'hFFFF_FFFF_FFFF_FFAB, 0, 64'h0);
        chk("R3 be lane3", o_be, 8'h08);
        chk("R4 wdata lane3", o_wdata, 64'h0000_0000_AB00_0000);
        chk("R8 delta", u_delta, 3'b110);
    endtask

    task automatic t_byte_store_inc();
        do_op(3'b111, 64'hFFFF_FFFF, 64'hCD, 0, 64'h0);
        chk("R3 be lane7", o_be, 8'h80);
        chk("R4 wdata lane7", o_wdata, 64'hCD00_0000_0000_0000);
        chk("R5 last low byte", o_cache, 1);
        chk("R8 top crosses bound", u_top, 64'h1_0000_0000);
        chk("R8 delta", u_delta, 3'b111);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_code = 3'b000;
        stk_top = '0; stk_next = '0; mem_ready = 1'b0; mem_rdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cell_fetch();
        t_cell_fetch_inc_misaligned();
        t_cell_store();
        t_cell_store_inc();
        t_byte_fetch();
        t_byte_fetch_inc();
        t_byte_store();
        t_byte_store_inc();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule